// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block decides where a processor goes when a trap is raised. Given the trap cause, the faulting PC, the trap value and the current privilege, it routes the trap to one of four outcomes. A trap raised while already halted in debug mode only redirects the PC inside the debug program. A software breakpoint whose per-privilege enable is set diverts into debug mode. Otherwise the trap is taken in supervisor mode when it is delegated, or in machine mode when it is not. Exceptions and interrupts consult separate delegation masks.

For each trap the unit produces the redirect PC, the new privilege, a write strobe for the chosen handler's cause/EPC/value/status fields together with their values, and the debug state to record on debug entry. The surrounding CSR file applies these writes. All outputs are registered. A request seen at one rising edge shows its full effect on the outputs after that edge, and each strobe lasts exactly one cycle.

Top module: `trap_entry_unit`

## Requirements
- R1: After synchronous reset, `redirect_valid`, `prv_we`, `s_we`, `m_we` and `dbg_enter` are 0 and `new_prv` is 3 (privilege encoding U=0, S=1, M=3).
- R2: A trap request sampled at a rising edge makes `redirect_valid` high for exactly the following cycle. With no request, every strobe (`redirect_valid`, `prv_we`, `s_we`, `m_we`, `dbg_enter`) is low, and at most one of `s_we`, `m_we`, `dbg_enter` is ever high.
- R3: While `dbg_cause_cur` is nonzero, a breakpoint (non-interrupt cause code 3) redirects to `DBG_ROM_ENTRY` and any other trap redirects to `DBG_EXC_VEC`. In both cases `prv_we`, `s_we`, `m_we` and `dbg_enter` stay low.
- R4: Outside debug mode, a breakpoint raised in U, S or M with the enable for that privilege set raises `dbg_enter`. It sets `dbg_cause_out` to 1, `dbg_prv_out` to the old privilege, `dbg_pc` to `trap_epc`, `new_prv` to 3 with `prv_we`, and redirects to `DBG_ROM_ENTRY`.
- R5: A breakpoint enable for a privilege other than the current one has no effect: the breakpoint is handled as an ordinary trap.
- R6: The cause MSB marks an interrupt. The remaining bits form the index. Interrupts test `mideleg[index]` and exceptions test `medeleg[index]`. An index of XLEN or more is never delegated.
- R7: A delegated trap (current privilege U or S, mask bit set) redirects to `stvec` and pulses `s_we`. It outputs `s_cause`=cause, `s_epc`=epc, `s_tval`=tval, `s_pie`=`cur_sie` and `s_pp`=old privilege bit 0, and sets `new_prv`=1. `s_we` implies the SIE bit is cleared.
- R8: A machine trap redirects to `mtvec` with bit 0 cleared. It adds 4×index only when `mtvec[0]` is 1 and the trap is an interrupt.
- R9: A machine trap pulses `m_we` and outputs `m_cause`, `m_epc`, `m_tval`, `m_pie`=`cur_mie` and the 2-bit `m_pp`=old privilege, and sets `new_prv`=3. `m_we` implies MIE is cleared.
- R10: A trap raised in M mode is never delegated, whatever the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_cause | input | XLEN | Cause; MSB set for interrupts |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| cur_prv | input | 2 | Current privilege |
| cur_sie | input | 1 | Current supervisor interrupt enable |
| cur_mie | input | 1 | Current machine interrupt enable |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap base |
| mtvec | input | XLEN | Machine trap base; bit 0 selects vectored interrupts |
| ebreak_en_m | input | 1 | Breakpoint-to-debug enable in M |
| ebreak_en_s | input | 1 | Breakpoint-to-debug enable in S |
| ebreak_en_u | input | 1 | Breakpoint-to-debug enable in U |
| dbg_cause_cur | input | 3 | Current debug cause; nonzero means halted in debug |
| redirect_valid | output | 1 | Redirect strobe |
| redirect_pc | output | XLEN | New PC |
| prv_we | output | 1 | Privilege write strobe |
| new_prv | output | 2 | New privilege |
| s_we | output | 1 | Supervisor trap CSR write strobe |
| s_cause | output | XLEN | Supervisor cause value |
| s_epc | output | XLEN | Supervisor EPC value |
| s_tval | output | XLEN | Supervisor trap value |
| s_pie | output | 1 | New SPIE value |
| s_pp | output | 1 | New SPP value |
| m_we | output | 1 | Machine trap CSR write strobe |
| m_cause | output | XLEN | Machine cause value |
| m_epc | output | XLEN | Machine EPC value |
| m_tval | output | XLEN | Machine trap value |
| m_pie | output | 1 | New MPIE value |
| m_pp | output | 2 | New MPP value |
| dbg_enter | output | 1 | Debug entry strobe |
| dbg_cause_out | output | 3 | Debug cause to record |
| dbg_prv_out | output | 2 | Privilege saved on debug entry |
| dbg_pc | output | XLEN | PC saved on debug entry |

## Verification
The same cause is driven from U, S and M with the delegation bit set, which separates the privilege gate from the mask lookup. A cause whose bit is set in only one of the two masks is raised once as an exception and once as an interrupt, which shows that the masks are not swapped. Vectored and direct `mtvec` are each tried with an exception and with an interrupt, so that an offset applied to the wrong class shows up. Breakpoints are raised with matching and mismatched enables and while halted in debug, and a cause index above XLEN is raised with all mask bits set.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  typedef enum logic [2:0] {
    RT_NONE,
    RT_DBG_REDIR,
    RT_DBG_ENTER,
    RT_SUPER,
    RT_MACHINE
  } route_e;
endpackage

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int BKPT_CODE = 3
) (
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      cur_prv,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic            ebreak_en_m,
  input  logic            ebreak_en_s,
  input  logic            ebreak_en_u,
  input  logic            in_debug,
  output route_e          route,
  output logic            is_irq,
  output logic            is_bkpt,
  output logic [XLEN-2:0] idx
);
  localparam int IDXW = $clog2(XLEN);

  logic            idx_in_range;
  logic [IDXW-1:0] sel;
  logic [XLEN-1:0] mask;
  logic            deleg_bit;
  logic            ebreak_hit;
  logic            prv_delegable;

  assign is_irq  = cause[XLEN-1];
  assign idx     = cause[XLEN-2:0];
  assign is_bkpt = !is_irq && (idx == (XLEN-1)'(BKPT_CODE));

  // Index must fit the mask width to be looked up at all
  assign idx_in_range = (idx >> IDXW) == '0;
  assign sel          = idx[IDXW-1:0];
  assign mask         = is_irq ? mideleg : medeleg;
  assign deleg_bit    = idx_in_range && mask[sel];

  always_comb begin
    unique case (cur_prv)
      PRV_M:   ebreak_hit = ebreak_en_m;
      PRV_S:   ebreak_hit = ebreak_en_s;
      PRV_U:   ebreak_hit = ebreak_en_u;
      default: ebreak_hit = 1'b0;
    endcase
  end

  assign prv_delegable = (cur_prv == PRV_U) || (cur_prv == PRV_S);

  always_comb begin
    if (in_debug)                      route = RT_DBG_REDIR;
    else if (is_bkpt && ebreak_hit)    route = RT_DBG_ENTER;
    else if (prv_delegable && deleg_bit) route = RT_SUPER;
    else                               route = RT_MACHINE;
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter logic [XLEN-1:0] DBG_ROM_ENTRY = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_VEC   = 'h808
) (
  input  route_e          route,
  input  logic            is_irq,
  input  logic            is_bkpt,
  input  logic [XLEN-2:0] idx,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  output logic [XLEN-1:0] target
);
  logic [XLEN:0]   off_full;
  logic [XLEN-1:0] m_base;
  logic [XLEN-1:0] m_off;

  assign off_full = {idx, 2'b00};
  assign m_base   = {mtvec[XLEN-1:1], 1'b0};
  assign m_off    = (mtvec[0] && is_irq) ? off_full[XLEN-1:0] : '0;

  always_comb begin
    unique case (route)
      RT_DBG_REDIR: target = is_bkpt ? DBG_ROM_ENTRY : DBG_EXC_VEC;
      RT_DBG_ENTER: target = DBG_ROM_ENTRY;
      RT_SUPER:     target = stvec;
      default:      target = m_base + m_off;
    endcase
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter int              BKPT_CODE     = 3,
  parameter int              SWBP_DBG_CODE = 1,
  parameter logic [XLEN-1:0] DBG_ROM_ENTRY = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_VEC   = 'h808
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] trap_tval,
  input  logic [1:0]      cur_prv,
  input  logic            cur_sie,
  input  logic            cur_mie,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  input  logic            ebreak_en_m,
  input  logic            ebreak_en_s,
  input  logic            ebreak_en_u,
  input  logic [2:0]      dbg_cause_cur,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            prv_we,
  output logic [1:0]      new_prv,
  output logic            s_we,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_tval,
  output logic            s_pie,
  output logic            s_pp,
  output logic            m_we,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_tval,
  output logic            m_pie,
  output logic [1:0]      m_pp,
  output logic            dbg_enter,
  output logic [2:0]      dbg_cause_out,
  output logic [1:0]      dbg_prv_out,
  output logic [XLEN-1:0] dbg_pc
);
  route_e          route;
  logic            is_irq;
  logic            is_bkpt;
  logic [XLEN-2:0] idx;
  logic [XLEN-1:0] target;

  trap_router #(.XLEN(XLEN), .BKPT_CODE(BKPT_CODE)) u_router (
    .cause       (trap_cause),
    .cur_prv     (cur_prv),
    .medeleg     (medeleg),
    .mideleg     (mideleg),
    .ebreak_en_m (ebreak_en_m),
    .ebreak_en_s (ebreak_en_s),
    .ebreak_en_u (ebreak_en_u),
    .in_debug    (dbg_cause_cur != 3'd0),
    .route       (route),
    .is_irq      (is_irq),
    .is_bkpt     (is_bkpt),
    .idx         (idx)
  );

  trap_vector #(
    .XLEN(XLEN), .DBG_ROM_ENTRY(DBG_ROM_ENTRY), .DBG_EXC_VEC(DBG_EXC_VEC)
  ) u_vector (
    .route   (route),
    .is_irq  (is_irq),
    .is_bkpt (is_bkpt),
    .idx     (idx),
    .stvec   (stvec),
    .mtvec   (mtvec),
    .target  (target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      prv_we         <= 1'b0;
      new_prv        <= PRV_M;
      s_we           <= 1'b0;
      s_cause        <= '0;
      s_epc          <= '0;
      s_tval         <= '0;
      s_pie          <= 1'b0;
      s_pp           <= 1'b0;
      m_we           <= 1'b0;
      m_cause        <= '0;
      m_epc          <= '0;
      m_tval         <= '0;
      m_pie          <= 1'b0;
      m_pp           <= PRV_U;
      dbg_enter      <= 1'b0;
      dbg_cause_out  <= '0;
      dbg_prv_out    <= PRV_U;
      dbg_pc         <= '0;
    end else begin
      redirect_valid <= trap_valid;
      prv_we         <= 1'b0;
      s_we           <= 1'b0;
      m_we           <= 1'b0;
      dbg_enter      <= 1'b0;
      if (trap_valid) begin
        redirect_pc <= target;
        unique case (route)
          RT_DBG_ENTER: begin
            dbg_enter     <= 1'b1;
            dbg_cause_out <= 3'(SWBP_DBG_CODE);
            dbg_prv_out   <= cur_prv;
            dbg_pc        <= trap_epc;
            prv_we        <= 1'b1;
            new_prv       <= PRV_M;
          end
          RT_SUPER: begin
            s_we    <= 1'b1;
            s_cause <= trap_cause;
            s_epc   <= trap_epc;
            s_tval  <= trap_tval;
            s_pie   <= cur_sie;
            s_pp    <= cur_prv[0];
            prv_we  <= 1'b1;
            new_prv <= PRV_S;
          end
          RT_MACHINE: begin
            m_we    <= 1'b1;
            m_cause <= trap_cause;
            m_epc   <= trap_epc;
            m_tval  <= trap_tval;
            m_pie   <= cur_mie;
            m_pp    <= cur_prv;
            prv_we  <= 1'b1;
            new_prv <= PRV_M;
          end
          default: ;
        endcase
      end
    end
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({s_we, m_we, dbg_enter}));
  assert_trap_redirect_R2: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> redirect_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> !redirect_valid && !prv_we && !s_we && !m_we && !dbg_enter);
  assert_debug_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && dbg_cause_cur != 3'd0) |=> !prv_we && !s_we && !m_we && !dbg_enter);
  assert_dbg_entry_R4: assert property (@(posedge clk) disable iff (rst)
    dbg_enter |-> (redirect_pc == DBG_ROM_ENTRY) && (new_prv == PRV_M) && prv_we);
  assert_s_prv_R7: assert property (@(posedge clk) disable iff (rst)
    s_we |-> (new_prv == PRV_S) && prv_we);
  assert_m_prv_R9: assert property (@(posedge clk) disable iff (rst)
    m_we |-> (new_prv == PRV_M) && prv_we);
  assert_mmode_local_R10: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && cur_prv == PRV_M && dbg_cause_cur == 3'd0) |=> !s_we);
endmodule

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
  localparam int XLEN = 32;
  localparam logic [31:0] ROM = 32'h800;
  localparam logic [31:0] EXV = 32'h808;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_valid = 1'b0;
  logic [31:0] trap_cause = '0, trap_epc = '0, trap_tval = '0;
  logic [1:0]  cur_prv = 2'd0;
  logic cur_sie = 1'b0, cur_mie = 1'b0;
  logic [31:0] medeleg = '0, mideleg = '0, stvec = '0, mtvec = '0;
  logic ebreak_en_m = 1'b0, ebreak_en_s = 1'b0, ebreak_en_u = 1'b0;
  logic [2:0] dbg_cause_cur = '0;

  logic redirect_valid, prv_we, s_we, m_we, dbg_enter, s_pie, s_pp, m_pie;
  logic [31:0] redirect_pc, s_cause, s_epc, s_tval, m_cause, m_epc, m_tval, dbg_pc;
  logic [1:0] new_prv, m_pp, dbg_prv_out;
  logic [2:0] dbg_cause_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .DBG_ROM_ENTRY(ROM), .DBG_EXC_VEC(EXV)) i_trap_entry_unit (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .trap_tval(trap_tval), .cur_prv(cur_prv),
    .cur_sie(cur_sie), .cur_mie(cur_mie), .medeleg(medeleg), .mideleg(mideleg),
    .stvec(stvec), .mtvec(mtvec), .ebreak_en_m(ebreak_en_m),
    .ebreak_en_s(ebreak_en_s), .ebreak_en_u(ebreak_en_u),
    .dbg_cause_cur(dbg_cause_cur), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .prv_we(prv_we), .new_prv(new_prv),
    .s_we(s_we), .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval),
    .s_pie(s_pie), .s_pp(s_pp), .m_we(m_we), .m_cause(m_cause),
    .m_epc(m_epc), .m_tval(m_tval), .m_pie(m_pie), .m_pp(m_pp),
    .dbg_enter(dbg_enter), .dbg_cause_out(dbg_cause_out),
    .dbg_prv_out(dbg_prv_out), .dbg_pc(dbg_pc)
  );

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
    end
  endtask

  // Raise one trap; returns at the negedge after the registering edge
  task automatic fire(input logic [31:0] cause, input logic [1:0] prv);
    @(negedge clk);
    trap_cause = cause;
    cur_prv    = prv;
    trap_epc   = 32'h4000_0100 + {28'd0, cause[3:0], 2'b00};
    trap_tval  = 32'hBEEF_0000 | cause;
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 redirect_valid", redirect_valid, 0);
    chk("R1 prv_we", prv_we, 0);
    chk("R1 s_we/m_we/dbg_enter", {s_we, m_we, dbg_enter}, 0);
    chk("R1 new_prv", new_prv, 3);
  endtask

  task automatic t_mtrap_exc;
    mtvec = 32'h1001; cur_mie = 1'b1; medeleg = '0;
    fire(32'd2, 2'd0);
    chk("R9 m_we", m_we, 1);
    chk("R8 exception ignores vector", redirect_pc, 32'h1000);
    chk("R9 m_cause", m_cause, 2);
    chk("R9 m_epc", m_epc, 32'h4000_0108);
    chk("R9 m_tval", m_tval, 32'hBEEF_0002);
    chk("R9 m_pie", m_pie, 1);
    chk("R9 m_pp", m_pp, 0);
    chk("R9 new_prv", new_prv, 3);
    chk("R2 redirect_valid", redirect_valid, 1);
    @(negedge clk);
    chk("R2 strobes drop", {redirect_valid, prv_we, s_we, m_we, dbg_enter}, 0);
  endtask

  task automatic t_mtrap_irq;
    mtvec = 32'h1001;
    fire(32'h8000_0007, 2'd1);
    chk("R8 vectored irq", redirect_pc, 32'h101C);
    chk("R9 m_pp from S", m_pp, 1);
    mtvec = 32'h2000;
    fire(32'h8000_0007, 2'd0);
    chk("R8 direct irq", redirect_pc, 32'h2000);
  endtask

  task automatic t_sdeleg;
    stvec = 32'h3000; medeleg = 32'h100; cur_sie = 1'b1;
    fire(32'd8, 2'd0);
    chk("R7 s_we", {s_we, m_we}, 2'b10);
    chk("R7 pc", redirect_pc, 32'h3000);
    chk("R7 s_cause", s_cause, 8);
    chk("R7 s_epc", s_epc, 32'h4000_0120);
    chk("R7 s_tval", s_tval, 32'hBEEF_0008);
    chk("R7 s_pie", s_pie, 1);
    chk("R7 s_pp U", s_pp, 0);
    chk("R7 new_prv", new_prv, 1);
    cur_sie = 1'b0;
    fire(32'd8, 2'd1);
    chk("R7 s_pp S", s_pp, 1);
    chk("R7 s_pie low", s_pie, 0);
  endtask

  task automatic t_masks;
    mtvec = 32'h2000; stvec = 32'h3000;
    medeleg = 32'h20; mideleg = '0;
    fire(32'h8000_0005, 2'd0);
    chk("R6 irq ignores medeleg", {s_we, m_we}, 2'b01);
    medeleg = '0; mideleg = 32'h20;
    fire(32'h8000_0005, 2'd0);
    chk("R6 irq uses mideleg", {s_we, m_we}, 2'b10);
    fire(32'd5, 2'd0);
    chk("R6 exc ignores mideleg", {s_we, m_we}, 2'b01);
    medeleg = 32'hFFFF_FFFF; mideleg = 32'hFFFF_FFFF;
    fire(32'd40, 2'd0);
    chk("R6 index beyond XLEN", {s_we, m_we}, 2'b01);
  endtask

  task automatic t_mmode;
    medeleg = 32'hFFFF_FFFF; mideleg = 32'hFFFF_FFFF; mtvec = 32'h2000;
    fire(32'd8, 2'd3);
    chk("R10 M never delegated", {s_we, m_we}, 2'b01);
    chk("R10 m_pp", m_pp, 3);
    medeleg = '0; mideleg = '0;
  endtask

  task automatic t_dbg_entry;
    ebreak_en_s = 1'b1; mtvec = 32'h2000;
    fire(32'd3, 2'd1);
    chk("R4 dbg_enter", {dbg_enter, s_we, m_we}, 3'b100);
    chk("R4 pc", redirect_pc, ROM);
    chk("R4 cause", dbg_cause_out, 1);
    chk("R4 prv saved", dbg_prv_out, 1);
    chk("R4 pc saved", dbg_pc, 32'h4000_010C);
    chk("R4 new_prv", {prv_we, new_prv}, 3'b111);
    fire(32'd3, 2'd0);
    chk("R5 other enable ignored", {dbg_enter, m_we}, 2'b01);
    chk("R5 pc", redirect_pc, 32'h2000);
    ebreak_en_s = 1'b0; ebreak_en_m = 1'b1;
    fire(32'd3, 2'd3);
    chk("R4 M enable", dbg_enter, 1);
    chk("R4 prv saved M", dbg_prv_out, 3);
    ebreak_en_m = 1'b0;
  endtask

  task automatic t_in_debug;
    dbg_cause_cur = 3'd1; ebreak_en_u = 1'b1; medeleg = 32'hFFFF_FFFF;
    fire(32'd3, 2'd0);
    chk("R3 bkpt to ROM", redirect_pc, ROM);
    chk("R3 no writes", {prv_we, s_we, m_we, dbg_enter}, 0);
    fire(32'd5, 2'd0);
    chk("R3 other to vec", redirect_pc, EXV);
    chk("R3 no writes 2", {prv_we, s_we, m_we, dbg_enter}, 0);
    dbg_cause_cur = '0; ebreak_en_u = 1'b0; medeleg = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mtrap_exc();
    t_mtrap_irq();
    t_sdeleg();
    t_masks();
    t_mmode();
    t_dbg_entry();
    t_in_debug();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule